// File: doc/BRIEF.md
# Bus Bridge First-Error Capture Register

This block logs bus errors seen by a bus bridge. Four error kinds are tracked: master abort, target abort, retry limit exceeded and parity error. Each kind arrives as a one-cycle strobe that carries the faulting address, a byte mask and a block-transfer flag. The first error taken when no error is pending becomes the primary error. Its kind is flagged in the upper status bits, and its address and qualifiers are frozen in the status and address registers. Any error that follows while a primary is still pending only sets a sticky secondary flag for its kind.

Software reads the status word, the captured address and a one-bit control register over a small register port. It clears flags by writing ones to them. An interrupt line stays high while the control enable is set and any flag is set.

Top module: `errlog_capture`

## Requirements
- R1: After synchronous reset, the status word, address register, control register, `reg_rdata` and `irq_o` are all zero.
- R2: With no primary flag set, a strobe on `evt_strb[k]` (k=0 master abort, 1 target abort, 2 retry, 3 parity) sets status bit 63-k. The same event captures the address into the address register, the byte mask into status bits 47:32, address bits 5:3 into status bits 31:29 and the block flag into status bit 28.
- R3: With no primary flag set, if several strobes arrive in one cycle, the lowest index becomes the primary. Each of the others sets its secondary bit 59-k. At most one primary bit is ever set.
- R4: While any primary bit is set, a new strobe sets only secondary bit 59-k. The address register and the qualifier fields keep their values.
- R5: A write to status (`reg_sel`=0) clears exactly those flag bits in 63:56 where `reg_wdata` holds a one. Ones written to other bit positions have no effect.
- R6: A strobe in the same cycle as a status clear write is never lost. It is classified against the primary state that held before the write, and it is set after the clear.
- R7: `irq_o` is a register equal to control bit 0 AND (any flag in 63:56 set). It changes on the same clock edge as the flags.
- R8: `reg_rd` with `reg_sel` 0/1/2/3 returns status / address / control (bit 0) / zero on `reg_rdata` after the next clock edge.
- R9: Once all primary bits are cleared, the next strobe is captured as a new primary with freshly captured fields.
- R10: Writes with `reg_sel`=1 or 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_strb | input | 4 | Error strobes, one bit per kind |
| evt_addr | input | 64 | Faulting address of the event |
| evt_bmask | input | 16 | Byte mask of the event |
| evt_block | input | 1 | Event was a block transfer |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 status, 1 address, 2 control, 3 none |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data |
| irq_o | output | 1 | Error interrupt |

## Verification
The assertions assume that the qualifier inputs only matter in cycles where a strobe is present. They also assume that a status write and a strobe may land in the same cycle, and the checks are written to hold under that overlap. The stimulus drives every input away from the active edge and holds each strobe for exactly one cycle. It deliberately overlaps clear writes with new events, in both the primary-pending case and the idle case, so that the precedence rule is exercised from both sides.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
  localparam int STATUS_W   = 64;
  localparam int PRIM_TOP   = 63;
  localparam int SEC_TOP    = 59;
  localparam int BM_LO      = 32;
  localparam int OFF_LO     = 29;
  localparam int OFF_W      = 3;
  localparam int ADDR_OFF_LO = 3;
  localparam int BLK_BIT    = 28;
  localparam int CTL_EN_BIT = 0;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ADDR   = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/errlog_prio.sv
module errlog_prio #(
  parameter int N_KIND = 4
) (
  input  logic [N_KIND-1:0] req,
  output logic [N_KIND-1:0] win,
  output logic [N_KIND-1:0] rest
);
  logic [N_KIND:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N_KIND; i++) begin : g_pick
    assign win[i]    = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  assign rest = req & ~win;
endmodule

// File: rtl/errlog_flags.sv
module errlog_flags #(
  parameter int N_KIND = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_KIND-1:0] evt,
  input  logic [N_KIND-1:0] clr_prim,
  input  logic [N_KIND-1:0] clr_sec,
  output logic [N_KIND-1:0] prim_q,
  output logic [N_KIND-1:0] sec_q,
  output logic              capture,
  output logic              any_d
);
  logic [N_KIND-1:0] win;
  logic [N_KIND-1:0] rest;
  logic [N_KIND-1:0] prim_d;
  logic [N_KIND-1:0] sec_d;
  logic              pending;

  errlog_prio #(.N_KIND(N_KIND)) u_prio (
    .req  (evt),
    .win  (win),
    .rest (rest)
  );

  assign pending = |prim_q;

  always_comb begin
    prim_d  = prim_q & ~clr_prim;
    sec_d   = sec_q & ~clr_sec;
    capture = 1'b0;
    if (|evt) begin
      if (pending) begin
        sec_d = sec_d | evt;
      end else begin
        prim_d  = prim_d | win;
        sec_d   = sec_d | rest;
        capture = 1'b1;
      end
    end
  end

  assign any_d = |{prim_d, sec_d};

  always_ff @(posedge clk) begin
    if (rst) begin
      prim_q <= '0;
      sec_q  <= '0;
    end else begin
      prim_q <= prim_d;
      sec_q  <= sec_d;
    end
  end
endmodule

// File: rtl/errlog_fields.sv
module errlog_fields
  import errlog_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int BM_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BM_W-1:0]   bmask,
  input  logic              block,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BM_W-1:0]   bmask_q,
  output logic [OFF_W-1:0]  off_q,
  output logic              blk_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      bmask_q <= '0;
      off_q   <= '0;
      blk_q   <= 1'b0;
    end else if (capture) begin
      addr_q  <= addr;
      bmask_q <= bmask;
      off_q   <= addr[ADDR_OFF_LO +: OFF_W];
      blk_q   <= block;
    end
  end
endmodule

// File: rtl/errlog_regif.sv
module errlog_regif
  import errlog_pkg::*;
#(
  parameter int N_KIND = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [1:0]          reg_sel,
  input  logic [STATUS_W-1:0] reg_wdata,
  input  logic [STATUS_W-1:0] status_w,
  input  logic [STATUS_W-1:0] addr_w,
  input  logic                flags_any_d,
  output logic [N_KIND-1:0]   clr_prim,
  output logic [N_KIND-1:0]   clr_sec,
  output logic                ctl_en,
  output logic [STATUS_W-1:0] reg_rdata,
  output logic                irq_o
);
  logic wr_status;
  logic wr_ctrl;
  logic ctl_d;
  logic wdata_unused;

  assign wr_status    = reg_wr && (reg_sel == SEL_STATUS);
  assign wr_ctrl      = reg_wr && (reg_sel == SEL_CTRL);
  assign wdata_unused = ^reg_wdata;

  for (genvar k = 0; k < N_KIND; k++) begin : g_clr
    assign clr_prim[k] = wr_status & reg_wdata[PRIM_TOP-k];
    assign clr_sec[k]  = wr_status & reg_wdata[SEC_TOP-k];
  end

  assign ctl_d = wr_ctrl ? reg_wdata[CTL_EN_BIT] : ctl_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      ctl_en <= ctl_d;
      irq_o  <= ctl_d & flags_any_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_sel)
        SEL_STATUS: reg_rdata <= status_w;
        SEL_ADDR:   reg_rdata <= addr_w;
        SEL_CTRL:   reg_rdata <= {{(STATUS_W-1){1'b0}}, ctl_en};
        default:    reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/errlog_capture.sv
module errlog_capture
  import errlog_pkg::*;
#(
  parameter int N_KIND = 4,
  parameter int ADDR_W = 64,
  parameter int BM_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_KIND-1:0]   evt_strb,
  input  logic [ADDR_W-1:0]   evt_addr,
  input  logic [BM_W-1:0]     evt_bmask,
  input  logic                evt_block,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [1:0]          reg_sel,
  input  logic [STATUS_W-1:0] reg_wdata,
  output logic [STATUS_W-1:0] reg_rdata,
  output logic                irq_o
);
  logic [N_KIND-1:0]   prim_q;
  logic [N_KIND-1:0]   sec_q;
  logic [N_KIND-1:0]   clr_prim;
  logic [N_KIND-1:0]   clr_sec;
  logic                capture;
  logic                any_d;
  logic                ctl_en;
  logic [ADDR_W-1:0]   addr_q;
  logic [BM_W-1:0]     bmask_q;
  logic [OFF_W-1:0]    off_q;
  logic                blk_q;
  logic [STATUS_W-1:0] status_w;
  logic [STATUS_W-1:0] addr_w;

  errlog_flags #(.N_KIND(N_KIND)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt_strb),
    .clr_prim (clr_prim),
    .clr_sec  (clr_sec),
    .prim_q   (prim_q),
    .sec_q    (sec_q),
    .capture  (capture),
    .any_d    (any_d)
  );

  errlog_fields #(.ADDR_W(ADDR_W), .BM_W(BM_W)) u_fields (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .addr    (evt_addr),
    .bmask   (evt_bmask),
    .block   (evt_block),
    .addr_q  (addr_q),
    .bmask_q (bmask_q),
    .off_q   (off_q),
    .blk_q   (blk_q)
  );

  always_comb begin
    status_w = '0;
    for (int k = 0; k < N_KIND; k++) begin
      status_w[PRIM_TOP-k] = prim_q[k];
      status_w[SEC_TOP-k]  = sec_q[k];
    end
    status_w[BM_LO +: BM_W]   = bmask_q;
    status_w[OFF_LO +: OFF_W] = off_q;
    status_w[BLK_BIT]         = blk_q;
  end

  always_comb begin
    addr_w = '0;
    addr_w[ADDR_W-1:0] = addr_q;
  end

  errlog_regif #(.N_KIND(N_KIND)) u_regif (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .status_w    (status_w),
    .addr_w      (addr_w),
    .flags_any_d (any_d),
    .clr_prim    (clr_prim),
    .clr_sec     (clr_sec),
    .ctl_en      (ctl_en),
    .reg_rdata   (reg_rdata),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/errlog_capture_chk.sv
module errlog_capture_chk #(
  parameter int N_KIND = 4,
  parameter int ADDR_W = 64,
  parameter int BM_W   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [N_KIND-1:0] evt_strb,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic [63:0]       reg_wdata,
  input logic [N_KIND-1:0] prim_q,
  input logic [N_KIND-1:0] sec_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic [BM_W-1:0]   bmask_q,
  input logic              irq_o
);
  logic [N_KIND-1:0] chk_clr_sec;

  always_comb begin
    chk_clr_sec = '0;
    for (int k = 0; k < N_KIND; k++)
      chk_clr_sec[k] = reg_wr && (reg_sel == 2'd0) && reg_wdata[59-k];
  end

  AST_NEW_PRIMARY: assert property (@(posedge clk) disable iff (rst)
    ((prim_q == '0) && (evt_strb != '0)) |=> (prim_q != '0)); // R2

  AST_PRIM_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(prim_q)); // R3

  AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (prim_q != '0) |=> ($stable(addr_q) && $stable(bmask_q))); // R4

  AST_SEC_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((sec_q & ~chk_clr_sec) != '0) |=>
      ((sec_q & $past(sec_q & ~chk_clr_sec)) == $past(sec_q & ~chk_clr_sec))); // R5

  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (evt_strb != '0) |=> ((prim_q | sec_q) != '0)); // R6

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ((prim_q | sec_q) != '0)); // R7
endmodule

bind errlog_capture errlog_capture_chk #(
  .N_KIND(N_KIND), .ADDR_W(ADDR_W), .BM_W(BM_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .evt_strb  (evt_strb),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .prim_q    (prim_q),
  .sec_q     (sec_q),
  .addr_q    (addr_q),
  .bmask_q   (bmask_q),
  .irq_o     (irq_o)
);

// File: tb/test_errlog_capture.sv
module test_errlog_capture;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  evt_strb = '0;
  logic [63:0] evt_addr = '0;
  logic [15:0] evt_bmask = '0;
  logic        evt_block = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  errlog_capture i_errlog_capture (
    .clk(clk), .rst(rst), .evt_strb(evt_strb), .evt_addr(evt_addr),
    .evt_bmask(evt_bmask), .evt_block(evt_block), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [3:0]  evt;
    logic [63:0] addr;
    logic [15:0] bm;
    logic        blk;
    logic        wr;
    logic [1:0]  sel;
    logic [63:0] wdata;
    logic [63:0] exp_st;
    logic [63:0] exp_ad;
    logic        exp_irq;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    // R2: first master abort captured as primary
    '{4'h1, 64'h0000_1234_5678_9A28, 16'hBEEF, 1'b1, 1'b0, 2'd0, 64'h0,
      64'h8000_BEEF_B000_0000, 64'h0000_1234_5678_9A28, 1'b1, 8'd2},
    // R4: retry while primary pending -> secondary only
    '{4'h4, 64'h0000_0000_0000_FFF8, 16'h0001, 1'b0, 1'b0, 2'd0, 64'h0,
      64'h8200_BEEF_B000_0000, 64'h0000_1234_5678_9A28, 1'b1, 8'd4},
    // R5: clear only primary master abort
    '{4'h0, 64'h0, 16'h0, 1'b0, 1'b1, 2'd0, 64'h8000_0000_0000_0000,
      64'h0200_BEEF_B000_0000, 64'h0000_1234_5678_9A28, 1'b1, 8'd5},
    // R3: target abort + parity together, target abort wins
    '{4'hA, 64'h0000_0000_CAFE_0010, 16'h00F0, 1'b0, 1'b0, 2'd0, 64'h0,
      64'h4300_00F0_4000_0000, 64'h0000_0000_CAFE_0010, 1'b1, 8'd3},
    // R6: clear-all with event while primary pending
    '{4'h1, 64'h0000_0000_0000_0777, 16'hAAAA, 1'b1, 1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF,
      64'h0800_00F0_4000_0000, 64'h0000_0000_CAFE_0010, 1'b1, 8'd6},
    // R5: clear last secondary, interrupt drops
    '{4'h0, 64'h0, 16'h0, 1'b0, 1'b1, 2'd0, 64'h0800_0000_0000_0000,
      64'h0000_00F0_4000_0000, 64'h0000_0000_CAFE_0010, 1'b0, 8'd5},
    // R9: new primary with refreshed fields after clear
    '{4'h8, 64'h0000_0000_0000_0038, 16'hFFFF, 1'b1, 1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF,
      64'h1000_FFFF_F000_0000, 64'h0000_0000_0000_0038, 1'b1, 8'd9},
    // R10: write to address register ignored
    '{4'h0, 64'h0, 16'h0, 1'b0, 1'b1, 2'd1, 64'h0000_0000_0000_DEAD,
      64'h1000_FFFF_F000_0000, 64'h0000_0000_0000_0038, 1'b1, 8'd10}
  };

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input int req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [63:0] val);
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = sel;
    @(negedge clk);
    reg_rd = 1'b0;
    val = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [63:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check({63'b0, irq_o}, 64'h0, 1, "irq after reset");
    rd(2'd0, v); check(v, 64'h0, 1, "status after reset");
    rd(2'd1, v); check(v, 64'h0, 1, "address after reset");
    rd(2'd2, v); check(v, 64'h0, 1, "control after reset");

    // R8: enable interrupt, read control back
    wr(2'd2, 64'h1);
    rd(2'd2, v); check(v, 64'h1, 8, "control readback");

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      evt_strb = VEC[i].evt; evt_addr = VEC[i].addr; evt_bmask = VEC[i].bm;
      evt_block = VEC[i].blk; reg_wr = VEC[i].wr; reg_sel = VEC[i].sel;
      reg_wdata = VEC[i].wdata;
      @(negedge clk);
      evt_strb = '0; reg_wr = 1'b0; reg_wdata = '0;
      check({63'b0, irq_o}, {63'b0, VEC[i].exp_irq}, 7, "irq");
      rd(2'd0, v); check(v, VEC[i].exp_st, int'(VEC[i].req), "status");
      rd(2'd1, v); check(v, VEC[i].exp_ad, int'(VEC[i].req), "address");
    end

    // R7: disabling gates the interrupt though flags remain
    wr(2'd2, 64'h0);
    check({63'b0, irq_o}, 64'h0, 7, "irq disabled");
    // R8: select 3 reads zero
    rd(2'd3, v); check(v, 64'h0, 8, "unused select");
    rd(2'd0, v); check(v, 64'h1000_FFFF_F000_0000, 10, "status kept after control write");

    // R1: reset clears captured state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(2'd0, v); check(v, 64'h0, 1, "status after second reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule